// File: doc/BRIEF.md
# Descriptor Ring Ownership Engine

This block is the device half of a host/device descriptor ring scheme for a simple network controller. Receive and transmit rings live in a descriptor RAM that the block reaches through one synchronous read/write port. Each descriptor is four consecutive words: status, control, buffer pointer and a spare link word. A descriptor belongs to the device while bit 31 of its status word is set. The device hands it back by writing a status word with that bit clear.

When a frame completes on the receive side, the engine reads the ownership bit of the current receive descriptor. If the descriptor is host-owned, the frame is dropped and counted. Otherwise the engine reads the control word and writes back length and error status. The transmit side sleeps until the host writes a poll demand. It then walks owned descriptors, presents each one's byte count and segment flags to the transmitter, waits for completion, and writes back a result. It stops walking at the first host-owned descriptor. A control-word flag, not a count, closes each ring.

The host side uses a small register port: bus mode (software reset), poll demand, two ring bases and operation mode. A status word shows a three-bit state code for each process.

Top module: `desc_ring_engine`

## Requirements
- R1: After rst_n, or after a register write to index 0 with bit 0 set, both processes are stopped, stat_word bits 22:20 (transmit) and 19:17 (receive) read 0, and missed_cnt is 0.
- R2: Register index 3 holds the receive ring base and index 4 the transmit ring base, each a word address with its low two bits forced to 0. A base write is ignored unless its process is stopped. Starting a process loads its current pointer from its base.
- R3: Register index 6 is the operation mode: bit 1 runs receive and bit 13 runs transmit.
- R4: On an rx_frame pulse while receive is waiting, if the current status word has bit 31 set, the engine writes that word back as {0, length in bits 30:16, error in bit 15, zeros in bits 14:9, 1 in bit 8, zeros in bits 7:0}.
- R5: A frame that finds the current receive descriptor host-owned (bit 31 clear) is dropped. The word is not written, the pointer does not move, and missed_cnt increments.
- R6: After each descriptor, the pointer moves to the ring base if control bit 25 was set, and otherwise advances by four words.
- R7: Transmit leaves its suspended state only on a write of exactly 1 to register index 1. This applies after start and after it finds a host-owned descriptor.
- R8: While a transmit descriptor is being sent, tx_active is high and tx_count, tx_first, tx_last and tx_setup show control bits 10:0, 29, 30 and 27. They stay that way until tx_done.
- R9: Transmit write-back is 0x00008000 if tx_err is set, 0x7FFFFFFF for a clean setup descriptor, and 0 otherwise.
- R10: After a write-back, transmit goes on to the next descriptor without another poll demand.
- R11: State codes: receive 0 stopped, 1 fetching, 3 waiting, 5 writing back. Transmit 0 stopped, 1 fetching, 2 sending, 6 suspended, 7 writing back. Clearing a run bit stops the process once it is waiting or suspended.
- R12: A frame that arrives while receive is in the middle of a descriptor is dropped and counted. A frame that arrives while receive is stopped is ignored and not counted.
- R13: When both processes need the descriptor port in the same cycle, receive is served and transmit waits. Both complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| stat_word | output | 32 | Process states: transmit in bits 22:20, receive in bits 19:17 |
| missed_cnt | output | MW | Dropped receive frames |
| mem_en | output | 1 | Descriptor RAM access enable |
| mem_we | output | 1 | Descriptor RAM write enable |
| mem_addr | output | AW | Descriptor RAM word address |
| mem_wdata | output | 32 | Descriptor RAM write data |
| mem_rdata | input | 32 | Descriptor RAM read data, one cycle after the read |
| rx_frame | input | 1 | Frame completion pulse |
| rx_len | input | 15 | Frame length including CRC |
| rx_err | input | 1 | Frame error flag |
| tx_active | output | 1 | Descriptor being transmitted |
| tx_count | output | CW | Buffer byte count |
| tx_first | output | 1 | First segment flag |
| tx_last | output | 1 | Last segment flag |
| tx_setup | output | 1 | Setup packet flag |
| tx_done | input | 1 | Transmit completion pulse |
| tx_err | input | 1 | Transmit error flag, valid with tx_done |

## Verification
The hardest situation to reach is a port collision: receive and transmit both want the descriptor port in the same cycle. The bench gets there by asserting a frame pulse and a poll demand on the same clock edge. Both walks then start their status reads together, and the bench afterwards checks both write-backs. Ring wrap and the ignored base write both depend on the engine's hidden pointer. The bench reaches them by handing the device whole laps of descriptors and by restarting a process, then reading which RAM word was touched.

// File: rtl/desc_ring_engine.sv
module desc_ring_engine #(
  parameter int AW = 8,
  parameter int CW = 11,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   stat_word,
  output logic [MW-1:0] missed_cnt,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          rx_frame,
  input  logic [14:0]   rx_len,
  input  logic          rx_err,
  output logic          tx_active,
  output logic [CW-1:0] tx_count,
  output logic          tx_first,
  output logic          tx_last,
  output logic          tx_setup,
  input  logic          tx_done,
  input  logic          tx_err
);
  localparam logic [2:0] A_BUS = 3'd0, A_POLL = 3'd1, A_RXB = 3'd3, A_TXB = 3'd4, A_OPM = 3'd6;
  localparam logic [AW-1:0] STEP = AW'(4);
  localparam logic [AW-1:0] CTLW = AW'(1);

  typedef enum logic [2:0] {R_STOP, R_IDLE, R_RDST, R_CHK, R_RDCT, R_GETCT, R_WB} rx_t;
  typedef enum logic [2:0] {T_STOP, T_SUSP, T_RDST, T_CHK, T_RDCT, T_GETCT, T_XMIT, T_WB} tx_t;

  rx_t rx_st;
  tx_t tx_st;
  logic rx_run, tx_run;
  logic [AW-1:0] rx_base, tx_base, rx_cur, tx_cur;
  logic [14:0] rx_len_q;
  logic rx_err_q, rx_eor, tx_err_q;
  logic [31:0] tx_ctl;
  logic [2:0] rx_code, tx_code;

  wire swr  = reg_we && reg_addr == A_BUS && reg_wdata[0];
  wire poll = reg_we && reg_addr == A_POLL && reg_wdata == 32'd1;
  wire rx_req = rx_st == R_RDST || rx_st == R_RDCT || rx_st == R_WB;
  wire tx_gnt = !rx_req;
  wire rx_miss_busy = rx_frame && rx_st != R_STOP && rx_st != R_IDLE;
  wire rx_miss_own  = rx_st == R_CHK && !mem_rdata[31];

  wire [31:0] rx_status = {1'b0, rx_len_q, rx_err_q, 6'b0, 1'b1, 8'b0};
  wire [31:0] tx_status = tx_err_q ? 32'h0000_8000 : (tx_ctl[27] ? 32'h7FFF_FFFF : 32'h0);

  assign tx_active = tx_st == T_XMIT;
  assign tx_count  = tx_ctl[CW-1:0];
  assign tx_first  = tx_ctl[29];
  assign tx_last   = tx_ctl[30];
  assign tx_setup  = tx_ctl[27];
  assign stat_word = {9'b0, tx_code, rx_code, 17'b0};

  always_comb begin
    case (rx_st)
      R_STOP:  rx_code = 3'd0;
      R_IDLE:  rx_code = 3'd3;
      R_WB:    rx_code = 3'd5;
      default: rx_code = 3'd1;
    endcase
    case (tx_st)
      T_STOP:  tx_code = 3'd0;
      T_SUSP:  tx_code = 3'd6;
      T_XMIT:  tx_code = 3'd2;
      T_WB:    tx_code = 3'd7;
      default: tx_code = 3'd1;
    endcase
  end

  always_comb begin
    mem_en = 1'b0;
    mem_we = 1'b0;
    mem_addr = '0;
    mem_wdata = '0;
    if (rx_st == R_RDST) begin
      mem_en = 1'b1; mem_addr = rx_cur;
    end else if (rx_st == R_RDCT) begin
      mem_en = 1'b1; mem_addr = rx_cur + CTLW;
    end else if (rx_st == R_WB) begin
      mem_en = 1'b1; mem_we = 1'b1; mem_addr = rx_cur; mem_wdata = rx_status;
    end else if (tx_st == T_RDST) begin
      mem_en = 1'b1; mem_addr = tx_cur;
    end else if (tx_st == T_RDCT) begin
      mem_en = 1'b1; mem_addr = tx_cur + CTLW;
    end else if (tx_st == T_WB) begin
      mem_en = 1'b1; mem_we = 1'b1; mem_addr = tx_cur; mem_wdata = tx_status;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_run <= 1'b0; tx_run <= 1'b0;
      rx_base <= '0; tx_base <= '0;
    end else begin
      if (swr) begin
        rx_run <= 1'b0; tx_run <= 1'b0;
      end else if (reg_we && reg_addr == A_OPM) begin
        rx_run <= reg_wdata[1]; tx_run <= reg_wdata[13];
      end
      if (reg_we && reg_addr == A_RXB && rx_st == R_STOP) rx_base <= {reg_wdata[AW-1:2], 2'b00};
      if (reg_we && reg_addr == A_TXB && tx_st == T_STOP) tx_base <= {reg_wdata[AW-1:2], 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st <= R_STOP; rx_cur <= '0; rx_len_q <= '0; rx_err_q <= 1'b0;
      rx_eor <= 1'b0; missed_cnt <= '0;
    end else if (swr) begin
      rx_st <= R_STOP; missed_cnt <= '0;
    end else begin
      missed_cnt <= missed_cnt + MW'(rx_miss_busy) + MW'(rx_miss_own);
      case (rx_st)
        R_STOP: if (rx_run) begin rx_cur <= rx_base; rx_st <= R_IDLE; end
        R_IDLE:
          if (!rx_run) rx_st <= R_STOP;
          else if (rx_frame) begin
            rx_len_q <= rx_len; rx_err_q <= rx_err; rx_st <= R_RDST;
          end
        R_RDST:  rx_st <= R_CHK;
        R_CHK:   rx_st <= mem_rdata[31] ? R_RDCT : R_IDLE;
        R_RDCT:  rx_st <= R_GETCT;
        R_GETCT: begin rx_eor <= mem_rdata[25]; rx_st <= R_WB; end
        R_WB: begin
          rx_cur <= rx_eor ? rx_base : rx_cur + STEP;
          rx_st <= R_IDLE;
        end
        default: rx_st <= R_STOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_st <= T_STOP; tx_cur <= '0; tx_ctl <= '0; tx_err_q <= 1'b0;
    end else if (swr) begin
      tx_st <= T_STOP;
    end else begin
      case (tx_st)
        T_STOP: if (tx_run) begin tx_cur <= tx_base; tx_st <= T_SUSP; end
        T_SUSP:
          if (!tx_run) tx_st <= T_STOP;
          else if (poll) tx_st <= T_RDST;
        T_RDST:  if (tx_gnt) tx_st <= T_CHK;
        T_CHK:   tx_st <= mem_rdata[31] ? T_RDCT : T_SUSP;
        T_RDCT:  if (tx_gnt) tx_st <= T_GETCT;
        T_GETCT: begin tx_ctl <= mem_rdata; tx_st <= T_XMIT; end
        T_XMIT:  if (tx_done) begin tx_err_q <= tx_err; tx_st <= T_WB; end
        T_WB:
          if (tx_gnt) begin
            tx_cur <= tx_ctl[25] ? tx_base : tx_cur + STEP;
            tx_st <= tx_run ? T_RDST : T_STOP;
          end
        default: tx_st <= T_STOP;
      endcase
    end
  end

  // R1
  swr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swr |=> (stat_word[22:17] == 6'd0 && missed_cnt == '0));

  // R4
  rx_handback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_st == R_WB) |-> (mem_we && !mem_wdata[31] && mem_wdata[8]));

  // R2
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_RXB && rx_st != R_STOP) |=> $stable(rx_base));

  // R7
  poll_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_st == T_SUSP && !poll) |=> (tx_st != T_RDST));

  // R13
  rx_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && !swr && (tx_st == T_RDST || tx_st == T_RDCT || tx_st == T_WB)) |=> $stable(tx_st));

  // R5
  drop_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_st == R_CHK && !mem_rdata[31] && !swr) |=> (rx_st == R_IDLE && !mem_we));
endmodule

// File: tb/tb_desc_ring_engine.sv
`timescale 1ns/1ps
module tb_desc_ring_engine;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [2:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic [31:0] stat_word; logic [15:0] missed_cnt;
  logic mem_en, mem_we; logic [7:0] mem_addr; logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = 0;
  logic rx_frame = 0; logic [14:0] rx_len = 0; logic rx_err = 0;
  logic tx_active; logic [10:0] tx_count; logic tx_first, tx_last, tx_setup;
  logic tx_done = 0, tx_err = 0;
  logic [31:0] ram [0:255];
  int n_chk = 0, n_err = 0;
  logic [7:0] exp_ptr;
  logic [15:0] exp_miss;

  always #4 clk = ~clk;

  desc_ring_engine dut (.*);

  always @(posedge clk)
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else mem_rdata <= ram[mem_addr];
    end

  // fields: own[16], err[15], len[14:0]
  localparam logic [16:0] RXV [0:4] = '{17'h10040, 17'h185EE, 17'h00050, 17'h10064, 17'h1003C};

  function automatic logic [31:0] rxs(input logic [14:0] len, input logic err);
    return {1'b0, len, err, 6'b0, 1'b1, 8'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [14:0] len, input logic err);
    @(negedge clk); rx_frame = 1; rx_len = len; rx_err = err;
    @(negedge clk); rx_frame = 0;
  endtask

  task automatic wait_act();
    for (int i = 0; i < 40 && !tx_active; i++) @(negedge clk);
  endtask

  task automatic finish_tx(input logic err);
    @(negedge clk); tx_done = 1; tx_err = err;
    @(negedge clk); tx_done = 0; tx_err = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] <= 32'h0;
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    chk("R1 reset status", stat_word, 32'h0);
    chk("R1 reset missed", {16'h0, missed_cnt}, 32'h0);
    chk("R8 reset tx_active", {31'h0, tx_active}, 32'h0);

    wr(3'd3, 32'h13);
    wr(3'd6, 32'h2);
    wait_n(2);
    chk("R11 rx waiting code", {29'h0, stat_word[19:17]}, 32'd3);
    chk("R3 tx stays stopped", {29'h0, stat_word[22:20]}, 32'd0);

    exp_ptr = 8'h10; exp_miss = 0;
    for (int v = 0; v < 5; v++) begin
      logic own; logic [14:0] len; logic err;
      own = RXV[v][16]; err = RXV[v][15]; len = RXV[v][14:0];
      @(negedge clk);
      ram[exp_ptr] <= own ? 32'h8000_0000 : 32'h0;
      ram[exp_ptr + 8'd1] <= (exp_ptr == 8'h18) ? 32'h0200_0000 : 32'h0;
      frame(len, err);
      wait_n(10);
      if (own) begin
        chk("R4 rx write-back", ram[exp_ptr], rxs(len, err));
        exp_ptr = (exp_ptr == 8'h18) ? 8'h10 : exp_ptr + 8'd4;
      end else begin
        exp_miss++;
        chk("R5 host-owned untouched", ram[exp_ptr], 32'h0);
      end
      chk("R5 missed count", {16'h0, missed_cnt}, {16'h0, exp_miss});
    end
    chk("R6 wrap pointer", {24'h0, exp_ptr}, 32'h14);

    // R12: second pulse lands mid-descriptor
    @(negedge clk); ram[8'h14] <= 32'h8000_0000; ram[8'h15] <= 32'h0;
    @(negedge clk); rx_frame = 1; rx_len = 15'd70; rx_err = 0;
    @(negedge clk); rx_frame = 1;
    @(negedge clk); rx_frame = 0;
    wait_n(10);
    exp_miss++;
    chk("R12 busy frame counted", {16'h0, missed_cnt}, {16'h0, exp_miss});
    chk("R12 first frame stored", ram[8'h14], rxs(15'd70, 1'b0));

    wr(3'd3, 32'h40);
    wr(3'd6, 32'h0);
    wait_n(2);
    chk("R11 rx stopped code", {29'h0, stat_word[19:17]}, 32'd0);
    frame(15'd90, 1'b0);
    wait_n(8);
    chk("R12 stopped frame ignored", {16'h0, missed_cnt}, {16'h0, exp_miss});
    @(negedge clk);
    ram[8'h10] <= 32'h8000_0000; ram[8'h11] <= 32'h0;
    ram[8'h40] <= 32'h8000_0000; ram[8'h41] <= 32'h0;
    wr(3'd6, 32'h2);
    wait_n(2);
    frame(15'd128, 1'b0);
    wait_n(10);
    chk("R2 restart uses old base", ram[8'h10], rxs(15'd128, 1'b0));
    chk("R2 ignored base untouched", ram[8'h40], 32'h8000_0000);
    exp_ptr = 8'h14;

    // transmit ring at 0x30 / 0x34
    wr(3'd4, 32'h30);
    @(negedge clk);
    ram[8'h30] <= 32'h8000_0000; ram[8'h31] <= 32'h6000_0064;
    ram[8'h34] <= 32'h8000_0000; ram[8'h35] <= 32'h0A00_00C0;
    wr(3'd6, 32'h2002);
    wait_n(10);
    chk("R7 no run before poll", {31'h0, tx_active}, 32'h0);
    chk("R11 tx suspended code", {29'h0, stat_word[22:20]}, 32'd6);
    wr(3'd1, 32'h2);
    wait_n(10);
    chk("R7 poll value 2 ignored", {31'h0, tx_active}, 32'h0);
    wr(3'd1, 32'h1);
    wait_act();
    chk("R8 tx active", {31'h0, tx_active}, 32'h1);
    chk("R8 tx fields", {18'h0, tx_first, tx_last, tx_setup, tx_count},
        {18'h0, 1'b1, 1'b1, 1'b0, 11'd100});
    chk("R11 tx sending code", {29'h0, stat_word[22:20]}, 32'd2);
    wait_n(3);
    chk("R8 held until done", {31'h0, tx_active}, 32'h1);
    finish_tx(1'b0);
    wait_act();
    chk("R9 clean write-back", ram[8'h30], 32'h0);
    chk("R10 continues without poll", {31'h0, tx_active}, 32'h1);
    chk("R8 setup fields", {18'h0, tx_first, tx_last, tx_setup, tx_count},
        {18'h0, 1'b0, 1'b0, 1'b1, 11'd192});
    finish_tx(1'b0);
    wait_n(12);
    chk("R9 setup write-back", ram[8'h34], 32'h7FFF_FFFF);
    chk("R6 tx wrap finds host-owned", {29'h0, stat_word[22:20]}, 32'd6);

    @(negedge clk); ram[8'h30] <= 32'h8000_0000; ram[8'h31] <= 32'h6000_0032;
    wr(3'd1, 32'h1);
    wait_act();
    chk("R6 tx wrapped to base", {21'h0, tx_count}, 32'd50);
    finish_tx(1'b1);
    wait_n(12);
    chk("R9 error write-back", ram[8'h30], 32'h0000_8000);
    chk("R7 suspended again", {29'h0, stat_word[22:20]}, 32'd6);

    // R13: frame and poll in the same cycle
    @(negedge clk);
    ram[8'h34] <= 32'h8000_0000; ram[8'h35] <= 32'h6200_0014;
    ram[8'h14] <= 32'h8000_0000; ram[8'h15] <= 32'h0;
    @(negedge clk);
    rx_frame = 1; rx_len = 15'd200; rx_err = 0;
    reg_we = 1; reg_addr = 3'd1; reg_wdata = 32'h1;
    @(negedge clk);
    rx_frame = 0; reg_we = 0;
    wait_act();
    chk("R13 tx fields after collision", {21'h0, tx_count}, 32'd20);
    finish_tx(1'b0);
    wait_n(10);
    chk("R13 tx write-back", ram[8'h34], 32'h0);
    chk("R13 rx write-back", ram[8'h14], rxs(15'd200, 1'b0));

    wr(3'd0, 32'h1);
    wait_n(1);
    chk("R1 soft reset status", stat_word, 32'h0);
    chk("R1 soft reset missed", {16'h0, missed_cnt}, 32'h0);
    chk("R3 run cleared by reset", {31'h0, tx_active}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule